// File: doc/BRIEF.md
# Prioritized Pin Function Multiplexer

This block is one slice of a general-purpose I/O port. Each of its pins can be taken over by one of several peripheral functions, or left as plain GPIO. The peripheral functions sit on a fixed priority ladder with four rungs. For every pin, the block finds the highest rung whose enable is asserted for that pin. That function then supplies the pin's output value and its output enable. When no rung is enabled, the pin is driven from a port data latch and a direction register.

With the default configuration the rungs are, from highest to lowest:

1. a local CAN transmitter;
2. a rerouted CAN controller;
3. a second rerouted CAN controller;
4. a rerouted SPI function that drives the serial clock.

The pad input passes through a synchronizer of parameterized depth, two flops by default. The synchronized value goes to every peripheral's receive input. It also feeds the data-register read path. A read of the data register returns the latch for pins whose direction bit is 1, and the synchronized pad for pins whose direction bit is 0. The ownership decision is purely combinational.

Top module: `pinmux_port`

## Requirements
- R1: After reset the data latch and the direction register are all zeros. A read of the direction register returns 0, and with no function enabled `pad_oe` is 0 on every pin.
- R2: When rung 0 is enabled on a pin, its output value and output enable drive that pin, whatever the other enables are.
- R3: Rung 1 owns a pin when its enable is 1 and rung 0 is disabled on that pin.
- R4: Rung 2 owns a pin when its enable is 1 and rungs 0 and 1 are disabled on that pin.
- R5: Rung 3 owns a pin only when all three higher rungs are disabled on that pin. It still wins over GPIO.
- R6: With no rung enabled on a pin, `pad_out` equals that pin's data latch bit and `pad_oe` equals its direction bit.
- R7: `reg_sel` selects the register: 0 is the data register and 1 is the direction register. For a data read, pins with direction 1 return the latch bit and pins with direction 0 return the synchronized pad bit. A direction read returns the direction register.
- R8: A write (`reg_wr`=1) takes effect at the next rising edge. It updates the selected register even while a peripheral owns the pin. A latch value written in this way appears on the pad as soon as GPIO regains the pin.
- R9: A change on `pad_in` reaches `fn_rx`, and the data read of an input pin, after exactly two rising edges: it is not yet visible after one.
- R10: While a peripheral owns a pin, `pad_oe` follows that peripheral's own output-enable bit. The GPIO direction bit has no effect on `pad_oe` in that state.
- R11: A change of any enable changes `pad_out` and `pad_oe` in the same cycle, with no clock edge needed.
- R12: Pins resolve independently. An enable on one pin does not alter the output of any other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 data, 1 direction |
| reg_wdata | input | N_PINS | Write data |
| reg_rdata | output | N_PINS | Read data of the selected register |
| fn_en | input | N_ALT*N_PINS | Function enables, rung k for pin p at bit k*N_PINS+p, rung 0 highest |
| fn_out | input | N_ALT*N_PINS | Function output values, same layout as fn_en |
| fn_oe | input | N_ALT*N_PINS | Function output enables, same layout as fn_en |
| pad_in | input | N_PINS | Raw pad input |
| pad_out | output | N_PINS | Resolved pad output value |
| pad_oe | output | N_PINS | Resolved pad output enable |
| fn_rx | output | N_PINS | Synchronized pad input to the peripherals |

## Verification
Ownership, `pad_out` and `pad_oe` depend on the inputs in the same cycle. The bench therefore drives the enables and the function signals on the falling edge and samples one time unit later, with no edge in between. Register writes are due one rising edge after the strobe, so each write task holds the strobe across exactly one edge and then reads back. The pad input needs two rising edges. The synchronization test samples shortly after the first edge, where the old value is expected. It samples again after the second edge, where the new value is expected on both `fn_rx` and the data read.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
   localparam logic SEL_DATA = 1'b0;
   localparam logic SEL_DIR  = 1'b1;

   typedef enum logic [1:0] {
      SYNC_RESET_LOW = 2'd0,
      SYNC_NO_RESET  = 2'd1
   } sync_kind_e;
endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync
   import pinmux_pkg::*;
#(
   parameter int         WIDTH  = 8,
   parameter int         STAGES = 2,
   parameter sync_kind_e KIND   = SYNC_RESET_LOW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (KIND == SYNC_RESET_LOW) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            end
         end
      end else begin : g_norst
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
   import pinmux_pkg::*;
#(
   parameter int N_PINS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sel,
   input  logic [N_PINS-1:0] wdata,
   input  logic [N_PINS-1:0] pin_sync,
   output logic [N_PINS-1:0] data_q,
   output logic [N_PINS-1:0] dir_q,
   output logic [N_PINS-1:0] rdata
);
   logic [N_PINS-1:0] data_view;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
      end else if (wr) begin
         if (sel == SEL_DATA) data_q <= wdata;
         else                 dir_q  <= wdata;
      end
   end

   // per pin: outputs read back the latch, inputs read the synchronized pad
   assign data_view = (data_q & dir_q) | (pin_sync & ~dir_q);
   assign rdata     = (sel == SEL_DIR) ? dir_q : data_view;
endmodule

// File: rtl/pinmux_resolve.sv
module pinmux_resolve #(
   parameter int N_ALT = 4
) (
   input  logic [N_ALT-1:0] en,
   input  logic [N_ALT-1:0] alt_out,
   input  logic [N_ALT-1:0] alt_oe,
   input  logic             gpio_out,
   input  logic             gpio_oe,
   output logic             pin_out,
   output logic             pin_oe
);
   // walk from lowest rung upward so the highest enabled rung is applied last
   always_comb begin
      pin_out = gpio_out;
      pin_oe  = gpio_oe;
      for (int k = N_ALT - 1; k >= 0; k--) begin
         if (en[k]) begin
            pin_out = alt_out[k];
            pin_oe  = alt_oe[k];
         end
      end
   end
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
   import pinmux_pkg::*;
#(
   parameter int         N_PINS      = 8,
   parameter int         N_ALT       = 4,
   parameter int         SYNC_STAGES = 2,
   parameter sync_kind_e SYNC_KIND   = SYNC_RESET_LOW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic                    reg_sel,
   input  logic [N_PINS-1:0]       reg_wdata,
   output logic [N_PINS-1:0]       reg_rdata,
   input  logic [N_ALT*N_PINS-1:0] fn_en,
   input  logic [N_ALT*N_PINS-1:0] fn_out,
   input  logic [N_ALT*N_PINS-1:0] fn_oe,
   input  logic [N_PINS-1:0]       pad_in,
   output logic [N_PINS-1:0]       pad_out,
   output logic [N_PINS-1:0]       pad_oe,
   output logic [N_PINS-1:0]       fn_rx
);
   localparam int FLAT_W = N_ALT * N_PINS;

   generate
      if (N_PINS < 1)      begin : g_bad_pins  $error("N_PINS must be at least 1"); end
      if (N_ALT < 1)       begin : g_bad_alt   $error("N_ALT must be at least 1"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
      if (FLAT_W > 4096)   begin : g_bad_flat  $error("N_ALT*N_PINS too large"); end
   endgenerate

   logic [N_PINS-1:0] pin_sync;
   logic [N_PINS-1:0] data_q;
   logic [N_PINS-1:0] dir_q;

   pinmux_sync #(
      .WIDTH  (N_PINS),
      .STAGES (SYNC_STAGES),
      .KIND   (SYNC_KIND)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   pinmux_regs #(
      .N_PINS (N_PINS)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .sel      (reg_sel),
      .wdata    (reg_wdata),
      .pin_sync (pin_sync),
      .data_q   (data_q),
      .dir_q    (dir_q),
      .rdata    (reg_rdata)
   );

   assign fn_rx = pin_sync;

   generate
      for (genvar p = 0; p < N_PINS; p++) begin : g_pin
         logic [N_ALT-1:0] en_p;
         logic [N_ALT-1:0] out_p;
         logic [N_ALT-1:0] oe_p;
         for (genvar k = 0; k < N_ALT; k++) begin : g_rung
            assign en_p[k]  = fn_en [k*N_PINS + p];
            assign out_p[k] = fn_out[k*N_PINS + p];
            assign oe_p[k]  = fn_oe [k*N_PINS + p];
         end
         pinmux_resolve #(
            .N_ALT (N_ALT)
         ) u_res (
            .en       (en_p),
            .alt_out  (out_p),
            .alt_oe   (oe_p),
            .gpio_out (data_q[p]),
            .gpio_oe  (dir_q[p]),
            .pin_out  (pad_out[p]),
            .pin_oe   (pad_oe[p])
         );
      end
   endgenerate
endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk
   import pinmux_pkg::*;
#(
   parameter int N_PINS      = 8,
   parameter int N_ALT       = 4,
   parameter int SYNC_STAGES = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    reg_wr,
   input logic                    reg_sel,
   input logic [N_PINS-1:0]       reg_wdata,
   input logic [N_PINS-1:0]       reg_rdata,
   input logic [N_ALT*N_PINS-1:0] fn_en,
   input logic [N_ALT*N_PINS-1:0] fn_out,
   input logic [N_ALT*N_PINS-1:0] fn_oe,
   input logic [N_PINS-1:0]       pad_in,
   input logic [N_PINS-1:0]       pad_out,
   input logic [N_PINS-1:0]       pad_oe,
   input logic [N_PINS-1:0]       fn_rx,
   input logic [N_PINS-1:0]       data_q,
   input logic [N_PINS-1:0]       dir_q
);
   localparam int LAST = N_ALT - 1;

   logic [N_PINS-1:0] en_top, en_last, any_en, above_last;
   logic [1:0]        since_rst;

   assign en_top  = fn_en[0 +: N_PINS];
   assign en_last = fn_en[LAST*N_PINS +: N_PINS];

   always_comb begin
      any_en     = '0;
      above_last = '0;
      for (int k = 0; k < N_ALT; k++) any_en |= fn_en[k*N_PINS +: N_PINS];
      for (int k = 0; k < LAST; k++)  above_last |= fn_en[k*N_PINS +: N_PINS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (data_q == '0 && dir_q == '0));

   a_r2_top_rung_owns: assert property (@(posedge clk) disable iff (!rst_n)
      (((pad_out ^ fn_out[0 +: N_PINS]) | (pad_oe ^ fn_oe[0 +: N_PINS])) & en_top) == '0);

   a_r5_last_rung_owns: assert property (@(posedge clk) disable iff (!rst_n)
      (((pad_out ^ fn_out[LAST*N_PINS +: N_PINS]) | (pad_oe ^ fn_oe[LAST*N_PINS +: N_PINS]))
        & en_last & ~above_last) == '0);

   a_r6_gpio_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      (((pad_out ^ data_q) | (pad_oe ^ dir_q)) & ~any_en) == '0);

   a_r7_read_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_DATA) |-> (((reg_rdata ^ data_q) & dir_q) == '0));

   a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_DATA) |=> (data_q == $past(reg_wdata)));

   generate
      if (SYNC_STAGES == 2) begin : g_sync2
         a_r9_two_edge_sync: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2) |-> (fn_rx == $past(pad_in, 2)));
      end
   endgenerate
endmodule

bind pinmux_port pinmux_port_chk #(
   .N_PINS      (N_PINS),
   .N_ALT       (N_ALT),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .fn_en     (fn_en),
   .fn_out    (fn_out),
   .fn_oe     (fn_oe),
   .pad_in    (pad_in),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .fn_rx     (fn_rx),
   .data_q    (data_q),
   .dir_q     (dir_q)
);

// File: tb/pinmux_port_test.sv
module pinmux_port_test;
   localparam int P      = 8;
   localparam int A      = 4;
   localparam int PERIOD = 10;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_wr = 1'b0;
   logic           reg_sel = 1'b0;
   logic [P-1:0]   reg_wdata = '0;
   logic [P-1:0]   reg_rdata;
   logic [A*P-1:0] fn_en = '0;
   logic [A*P-1:0] fn_out = '0;
   logic [A*P-1:0] fn_oe = '0;
   logic [P-1:0]   pad_in = '0;
   logic [P-1:0]   pad_out;
   logic [P-1:0]   pad_oe;
   logic [P-1:0]   fn_rx;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   pinmux_port #(.N_PINS(P), .N_ALT(A)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fn_en(fn_en),
      .fn_out(fn_out), .fn_oe(fn_oe), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .fn_rx(fn_rx)
   );

   task automatic check(input string req, input string what,
                        input logic [P-1:0] act, input logic [P-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic write_reg(input logic sel, input logic [P-1:0] val);
      @(negedge clk);
      reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic read_reg(input logic sel, output logic [P-1:0] val);
      reg_sel = sel;
      #1;
      val = reg_rdata;
   endtask

   task automatic set_rung(input int k, input logic [P-1:0] en,
                           input logic [P-1:0] o, input logic [P-1:0] oe);
      fn_en [k*P +: P] = en;
      fn_out[k*P +: P] = o;
      fn_oe [k*P +: P] = oe;
   endtask

   task automatic t_reset();
      logic [P-1:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "pad_oe in reset", pad_oe, '0);
      rst_n = 1'b1;
      @(negedge clk);
      read_reg(1'b1, v);
      check("R1", "dir after reset", v, '0);
      read_reg(1'b0, v);
      check("R1", "data after reset", v, '0);
      check("R1", "pad_oe after reset", pad_oe, '0);
   endtask

   task automatic t_gpio();
      write_reg(1'b0, 8'hC3);
      write_reg(1'b1, 8'h5A);
      #1;
      check("R6", "gpio pad_out", pad_out, 8'hC3);
      check("R6", "gpio pad_oe", pad_oe, 8'h5A);
   endtask

   // every enable combination on all pins, owner drives ones then zeros
   task automatic t_priority();
      write_reg(1'b1, 8'hFF);
      for (int m = 0; m < 16; m++) begin
         int    own;
         string tag;
         own = -1;
         for (int k = A - 1; k >= 0; k--) if (m[k]) own = k;
         tag = (own == 0) ? "R2" : (own == 1) ? "R3" : (own == 2) ? "R4" :
               (own == 3) ? "R5" : "R6";
         write_reg(1'b0, 8'h00);
         for (int k = 0; k < A; k++)
            set_rung(k, m[k] ? 8'hFF : 8'h00, (k == own) ? 8'hFF : 8'h00,
                     (k == own) ? 8'hFF : 8'h00);
         #1;
         check(tag, "owner high pad_out", pad_out, (own >= 0) ? 8'hFF : 8'h00);
         check(tag, "owner high pad_oe", pad_oe, 8'hFF);
         write_reg(1'b0, 8'hFF);
         for (int k = 0; k < A; k++)
            set_rung(k, m[k] ? 8'hFF : 8'h00, (k == own) ? 8'h00 : 8'hFF,
                     (k == own) ? 8'h00 : 8'hFF);
         #1;
         check(tag, "owner low pad_out", pad_out, (own >= 0) ? 8'h00 : 8'hFF);
         check(tag, "owner low pad_oe", pad_oe, (own >= 0) ? 8'h00 : 8'hFF);
      end
      for (int k = 0; k < A; k++) set_rung(k, '0, '0, '0);
   endtask

   task automatic t_oe_and_comb();
      @(negedge clk);
      write_reg(1'b1, 8'hFF);
      set_rung(1, 8'hFF, 8'hAA, 8'h0F);
      #1;
      check("R10", "peripheral oe overrides dir", pad_oe, 8'h0F);
      check("R3", "rung1 value", pad_out, 8'hAA);
      set_rung(0, 8'hFF, 8'h55, 8'hF0);
      #1;
      check("R11", "same-cycle takeover", pad_out, 8'h55);
      check("R11", "same-cycle oe", pad_oe, 8'hF0);
      set_rung(0, '0, '0, '0);
      set_rung(1, '0, '0, '0);
   endtask

   task automatic t_latch_while_owned();
      logic [P-1:0] v;
      write_reg(1'b1, 8'hFF);
      set_rung(2, 8'hFF, 8'h3C, 8'hFF);
      write_reg(1'b0, 8'hA5);
      #1;
      check("R8", "pad still owned", pad_out, 8'h3C);
      read_reg(1'b0, v);
      check("R8", "latch read while owned", v, 8'hA5);
      set_rung(2, '0, '0, '0);
      #1;
      check("R8", "latch on pad after release", pad_out, 8'hA5);
   endtask

   task automatic t_independent();
      write_reg(1'b0, 8'h00);
      write_reg(1'b1, 8'hFF);
      set_rung(0, 8'h08, 8'hFF, 8'hFF);
      #1;
      check("R12", "only pin 3 taken", pad_out, 8'h08);
      set_rung(0, '0, '0, '0);
   endtask

   task automatic t_sync_read();
      logic [P-1:0] v;
      write_reg(1'b0, 8'hF0);
      write_reg(1'b1, 8'hF0);
      @(negedge clk);
      pad_in = 8'h00;
      repeat (3) @(negedge clk);
      pad_in = 8'h6B;
      @(posedge clk); #1;
      check("R9", "fn_rx after one edge", fn_rx, 8'h00);
      @(posedge clk); #1;
      check("R9", "fn_rx after two edges", fn_rx, 8'h6B);
      read_reg(1'b0, v);
      check("R7", "mixed data read", v, 8'hF0 | (8'h6B & 8'h0F));
      read_reg(1'b1, v);
      check("R7", "direction read", v, 8'hF0);
   endtask

   initial begin
      t_reset();
      t_gpio();
      t_priority();
      t_oe_and_comb();
      t_latch_while_owned();
      t_independent();
      t_sync_read();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(PERIOD * 20000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule